// File: doc/BRIEF.md
# Multiplier-Free Binary Linear SVM Core

This block computes one linear support-vector decision over a binary feature vector. The vector holds the merged spike fires of 32 neurons over 20 consecutive merged bins. Each feature is 0 or 1. The products in the dot product therefore reduce to a choice between a stored coefficient and zero, so the datapath has no multiplier. A signed coefficient store and a bias register are written first through a simple write port. A start pulse then launches a serial sweep of 640 feature positions, one per clock cycle.

During the sweep the core publishes the index of the bin it is reading on `bin_ptr`. The surrounding logic presents the 32 fires of that bin on `fire_vec`, and an internal 32-to-1 selector picks one neuron per cycle. The accumulator is seeded with the bias on the start cycle. It then adds the selected coefficient, or zero, once for every position. When the sweep finishes, `done` rises and `decision` reports the sign class of the sum. Both stay valid until the next start.

Top module: `spike_svm_core`

## Requirements
- R1: A write with `cfg_addr` = bin*32 + neuron (bin 0..19, neuron 0..31) stores the 10-bit two's-complement `cfg_data` as the weight of that neuron in that bin. Only that position's term uses it.
- R2: A write to address 640 loads the 10-bit two's-complement bias. Writes to addresses 641 and above change nothing.
- R3: The sum starts from the bias. With every fire at 0, `decision` follows the sign of the bias alone.
- R4: Each position contributes its weight when its fire bit is 1 and nothing when it is 0. Bit n of `fire_vec` is neuron n of the bin shown on `bin_ptr`.
- R5: `bin_ptr` is 0 after reset, never exceeds 19, and steps through bins 0 to 19 in order during a sweep.
- R6: `done` rises on the 641st rising edge counting the edge that samples `start`. It then stays high until a new `start` is sampled, which clears it on that edge.
- R7: When `done` is high, `decision` is 1 if the final sum is zero or positive and 0 if it is negative. While `done` is low, `decision` is 0.
- R8: The sum is kept in 20 signed bits, so all weights and the bias at -512 (or all at 511) with every fire set still give the correct sign.
- R9: While a sweep is running, `start` and all writes are ignored. The result and the stored weights and bias are unaffected.
- R10: After reset, `done` and `decision` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for weights and bias |
| cfg_addr | input | 10 | Write address: 0..639 weights, 640 bias |
| cfg_data | input | 10 | Two's-complement write data |
| start | input | 1 | Starts a sweep when idle or finished |
| fire_vec | input | 32 | Merged fires of all neurons for bin `bin_ptr` |
| bin_ptr | output | 5 | Bin currently being read |
| done | output | 1 | Sweep complete, result valid |
| decision | output | 1 | Class bit: 1 for sum >= 0 |

## Verification
The checker assumes `fire_vec` always answers for the bin that `bin_ptr` currently shows. It also assumes that `start` and writes carry defined values after reset, since the hold and stability properties of `done` and `decision` reason only about the `start` pin. The bench therefore builds `fire_vec` combinationally from its own per-bin table, indexed by `bin_ptr`. It changes inputs only on falling edges, and it deliberately issues `start` and writes in the middle of a sweep, so the properties see those strobes while they must have no effect.

// File: rtl/svm_pkg.sv
package svm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } svm_state_e;

endpackage

// File: rtl/svm_coef_store.sv
module svm_coef_store #(
    parameter int DEPTH  = 640,
    parameter int COEF_W = 10,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [COEF_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [COEF_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    logic [COEF_W-1:0] mem_q [DEPTH];

    // storage is written only below DEPTH; the bias address lies above it
    always_ff @(posedge clk) begin
        if (we_i && (waddr_i < DEPTH_A)) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/svm_fire_sel.sv
module svm_fire_sel #(
    parameter int NEURONS = 32,
    parameter int SEL_W   = 5
) (
    input  logic [NEURONS-1:0] fires_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               fire_o
);

    always_comb begin
        fire_o = 1'b0;
        for (int n = 0; n < NEURONS; n++) begin
            if (sel_i == SEL_W'(n)) begin
                fire_o = fires_i[n];
            end
        end
    end

endmodule

// File: rtl/svm_accum.sv
module svm_accum #(
    parameter int COEF_W = 10,
    parameter int ACC_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_i,
    input  logic             step_i,
    input  logic [COEF_W-1:0] bias_i,
    input  logic [COEF_W-1:0] coef_i,
    input  logic             fire_i,
    output logic [ACC_W-1:0] acc_o
);

    localparam int EXT_W = ACC_W - COEF_W;

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] term;

    always_comb begin
        // product of a 0/1 feature and a weight is a plain select
        term = fire_i ? {{EXT_W{coef_i[COEF_W-1]}}, coef_i} : '0;
        if (seed_i) begin
            acc_d = {{EXT_W{bias_i[COEF_W-1]}}, bias_i};
        end else if (step_i) begin
            acc_d = acc_q + term;
        end else begin
            acc_d = acc_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/spike_svm_core.sv
module spike_svm_core #(
    parameter int NEURONS = 32,
    parameter int BINS    = 20,
    parameter int COEF_W  = 10,
    parameter int ACC_W   = 20,
    parameter int N_TERMS = NEURONS * BINS,
    parameter int ADDR_W  = $clog2(N_TERMS + 1),
    parameter int BIN_W   = $clog2(BINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [COEF_W-1:0]  cfg_data,
    input  logic               start,
    input  logic [NEURONS-1:0] fire_vec,
    output logic [BIN_W-1:0]   bin_ptr,
    output logic               done,
    output logic               decision
);

    import svm_pkg::*;

    localparam int NSEL_W = $clog2(NEURONS);
    localparam logic [ADDR_W-1:0] BIAS_A   = ADDR_W'(N_TERMS);
    localparam logic [ADDR_W-1:0] NEU_A    = ADDR_W'(NEURONS);
    localparam logic [NSEL_W-1:0] LAST_NEU = NSEL_W'(NEURONS - 1);
    localparam logic [BIN_W-1:0]  LAST_BIN = BIN_W'(BINS - 1);

    typedef struct packed {
        svm_state_e        st;
        logic [NSEL_W-1:0] neu;
        logic [BIN_W-1:0]  bin;
        logic [COEF_W-1:0] bias;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              seed, step, wr_ok;
    logic [ADDR_W-1:0] rd_addr;
    logic [COEF_W-1:0] coef;
    logic              fire_bit;
    logic [ACC_W-1:0]  acc_sum;

    always_comb begin
        ctl_d = ctl_q;
        seed  = 1'b0;
        step  = 1'b0;
        wr_ok = cfg_we && (ctl_q.st != ST_RUN);
        if (wr_ok && (cfg_addr == BIAS_A)) begin
            ctl_d.bias = cfg_data;
        end
        case (ctl_q.st)
            ST_RUN: begin
                step = 1'b1;
                if (ctl_q.neu == LAST_NEU) begin
                    ctl_d.neu = '0;
                    if (ctl_q.bin == LAST_BIN) begin
                        ctl_d.st = ST_DONE;
                    end else begin
                        ctl_d.bin = ctl_q.bin + 1'b1;
                    end
                end else begin
                    ctl_d.neu = ctl_q.neu + 1'b1;
                end
            end
            default: begin
                if (start) begin
                    ctl_d.st  = ST_RUN;
                    ctl_d.neu = '0;
                    ctl_d.bin = '0;
                    seed      = 1'b1;
                end
            end
        endcase
        rd_addr = ADDR_W'(ctl_q.bin) * NEU_A + ADDR_W'(ctl_q.neu);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, neu: '0, bin: '0, bias: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    svm_coef_store #(
        .DEPTH  (N_TERMS),
        .COEF_W (COEF_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk     (clk),
        .we_i    (wr_ok),
        .waddr_i (cfg_addr),
        .wdata_i (cfg_data),
        .raddr_i (rd_addr),
        .rdata_o (coef)
    );

    svm_fire_sel #(
        .NEURONS (NEURONS),
        .SEL_W   (NSEL_W)
    ) u_sel (
        .fires_i (fire_vec),
        .sel_i   (ctl_q.neu),
        .fire_o  (fire_bit)
    );

    svm_accum #(
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (seed),
        .step_i (step),
        .bias_i (ctl_q.bias),
        .coef_i (coef),
        .fire_i (fire_bit),
        .acc_o  (acc_sum)
    );

    assign bin_ptr  = ctl_q.bin;
    assign done     = (ctl_q.st == ST_DONE);
    assign decision = done && !acc_sum[ACC_W-1];

endmodule

// File: rtl/spike_svm_chk.sv
module spike_svm_chk #(
    parameter int BINS  = 20,
    parameter int BIN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [BIN_W-1:0] bin_ptr,
    input logic             done,
    input logic             decision
);

    assert_decision_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        decision |-> done);

    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    assert_decision_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(decision));

    assert_bin_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bin_ptr) < BINS);

endmodule

bind spike_svm_core spike_svm_chk #(
    .BINS  (BINS),
    .BIN_W (BIN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bin_ptr  (bin_ptr),
    .done     (done),
    .decision (decision)
);

// File: tb/spike_svm_core_tb.sv
`timescale 1ns/1ps
module spike_svm_core_tb;

    localparam int NEU  = 32;
    localparam int BINS = 20;
    localparam int NT   = NEU * BINS;
    localparam int SWEEP_EDGES = NT;

    // {weight seed[7:0], bias[9:0], fire seed[7:0]}
    localparam logic [25:0] VEC [6] = '{
        {8'd3,  10'h3F0, 8'd2},
        {8'd17, 10'h020, 8'd5},
        {8'd29, 10'h200, 8'd6},
        {8'd41, 10'h1FF, 8'd1},
        {8'd58, 10'h000, 8'd3},
        {8'd77, 10'h3FF, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [9:0]  cfg_data = '0;
    logic        start = 1'b0;
    logic [31:0] fire_vec;
    logic [4:0]  bin_ptr;
    logic        done, decision;

    int          coef_mem [NT];
    int          bias_m;
    logic [31:0] fire_mem [BINS];
    int          n_checks = 0;
    int          n_fail   = 0;

    always #10 clk = ~clk;

    always_comb fire_vec = fire_mem[bin_ptr];

    spike_svm_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .start    (start),
        .fire_vec (fire_vec),
        .bin_ptr  (bin_ptr),
        .done     (done),
        .decision (decision)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = 10'(addr);
        cfg_data = 10'(data);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic load_all();
        for (int i = 0; i < NT; i++) begin
            @(negedge clk);
            cfg_we   = 1'b1;
            cfg_addr = 10'(i);
            cfg_data = 10'(coef_mem[i]);
        end
        @(negedge clk);
        cfg_addr = 10'(NT);
        cfg_data = 10'(bias_m);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic model_dec();
        int s = bias_m;
        for (int b = 0; b < BINS; b++)
            for (int n = 0; n < NEU; n++)
                if (fire_mem[b][n]) s += coef_mem[b*NEU + n];
        return (s >= 0);
    endfunction

    // runs one sweep; when disturb is set, issues start and a bias write mid-sweep
    task automatic run_sweep(input logic exp, input string req, input bit disturb);
        int cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cnt < 3000) begin
            if (disturb && cnt == 100) begin
                start = 1'b1; cfg_we = 1'b1; cfg_addr = 10'(NT); cfg_data = 10'h3FF;
            end else if (disturb && cnt == 200) begin
                cfg_we = 1'b1; cfg_addr = 10'd0; cfg_data = 10'h200;
            end else begin
                start = 1'b0; cfg_we = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0; cfg_we = 1'b0;
        check(cnt == SWEEP_EDGES, "R6 done latency", cnt, SWEEP_EDGES);
        check(decision == exp, req, int'(decision), int'(exp));
    endtask

    task automatic clear_model();
        for (int i = 0; i < NT; i++) coef_mem[i] = 0;
        for (int b = 0; b < BINS; b++) fire_mem[b] = '0;
        bias_m = 0;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int b = 0; b < BINS; b++) fire_mem[b] = '0;
        repeat (3) @(negedge clk);
        // R10 reset state, R5 pointer at zero
        check(done == 1'b0, "R10 done after reset", int'(done), 0);
        check(decision == 1'b0, "R10 decision after reset", int'(decision), 0);
        check(bin_ptr == 5'd0, "R5 bin_ptr after reset", int'(bin_ptr), 0);
        rst_n = 1'b1;

        // table walk: R1 R4 R8 main function
        for (int v = 0; v < 6; v++) begin
            int cs = int'(VEC[v][25:18]);
            int fs = int'(VEC[v][7:0]);
            bias_m = int'($signed(VEC[v][17:8]));
            for (int i = 0; i < NT; i++)
                coef_mem[i] = ((i * cs * 7 + cs * 13) % 1024) - 512;
            for (int b = 0; b < BINS; b++)
                for (int n = 0; n < NEU; n++)
                    fire_mem[b][n] = (((b * 3 + n * 5 + fs) % 7) < (fs % 7));
            load_all();
            run_sweep(model_dec(), "R4 table vector", 1'b0);
        end

        // R3 bias seed with no fires; zero sum is positive (R7)
        clear_model();
        load_all();
        run_sweep(1'b1, "R7 zero sum gives 1", 1'b0);
        wr(NT, -1);
        run_sweep(1'b0, "R3 negative bias alone", 1'b0);
        wr(NT, 5);
        run_sweep(1'b1, "R3 positive bias alone", 1'b0);
        // R2 writes above the bias address do nothing
        wr(700, -300);
        wr(NT + 1, -512);
        run_sweep(1'b1, "R2 out-of-range write ignored", 1'b0);

        // R1 R4 single weight at bin 3 neuron 7
        wr(NT, 0);
        wr(3 * NEU + 7, -1);
        fire_mem[3] = 32'h0000_0080;
        run_sweep(1'b0, "R1 weight at bin3 neuron7", 1'b0);
        wr(NT, 1);
        run_sweep(1'b1, "R7 sum exactly zero", 1'b0);
        wr(NT, 0);
        fire_mem[3] = 32'h0000_0100;
        run_sweep(1'b1, "R4 fire at neighbour adds zero", 1'b0);

        // R8 extremes
        for (int i = 0; i < NT; i++) coef_mem[i] = -512;
        for (int b = 0; b < BINS; b++) fire_mem[b] = '1;
        bias_m = -512;
        load_all();
        run_sweep(1'b0, "R8 most negative sum", 1'b0);
        for (int i = 0; i < NT; i++) coef_mem[i] = 511;
        bias_m = 511;
        load_all();
        run_sweep(1'b1, "R8 most positive sum", 1'b0);

        // R9 disturbances during a sweep
        clear_model();
        bias_m = 1;
        load_all();
        run_sweep(1'b1, "R9 mid-sweep start and writes", 1'b1);
        fire_mem[0] = 32'h0000_0001;
        run_sweep(1'b1, "R9 stored values unchanged", 1'b0);

        // R6 done holds, then start clears it
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R6 done holds", int'(done), 1);
        check(decision == 1'b1, "R7 decision holds", int'(decision), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R6 start clears done", int'(done), 0);
        check(decision == 1'b0, "R7 decision low while busy", int'(decision), 0);
        check(bin_ptr == 5'd0, "R5 bin_ptr restarts", int'(bin_ptr), 0);
        repeat (NEU) @(negedge clk);
        check(bin_ptr == 5'd1, "R5 bin_ptr steps", int'(bin_ptr), 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule